// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the test access port of a single device. A sixteen-state controller advances on each rising edge of the test clock, steered by the mode-select input, and an active-low asynchronous reset returns it to Test-Logic-Reset at any time. A five-bit instruction register chooses which data register is placed between the serial input and the serial output.

Two data registers live inside the block: a one-bit bypass register and a 32-bit identification register whose value is a parameter. Six further registers sit outside the block: the boundary chain, the emulation instruction, control, data and status registers, and the program-counter sample register. The block reaches them through a one-hot select vector, a six-bit serial return input, and capture, shift and update strobes. Entering Test-Logic-Reset makes the identification instruction active, so a data scan made after reset with no prior instruction scan returns the identifier.

Top module: `tap_port`

## Requirements
- R1: While `trstN` is low the controller is held in Test-Logic-Reset, the active instruction is the identification opcode (`regSel` = 8'h02), `tdoEn` is 0 and all DR strobes are 0.
- R2: Five rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, and that state makes the identification opcode active again.
- R3: Capture-IR loads 5'b00001 into the instruction shift stage. In Shift-IR that stage leaves on `tdo` least significant bit first.
- R4: The decode drives one-hot `regSel`. Opcode 11111 sets bit 0 (bypass), 01000 sets bit 1 (identification), 00000 and 00001 set bit 2 (boundary), 00010 sets bit 3, 00100 sets bit 4, 00101 sets bit 5, 00110 sets bit 6 and 01111 sets bit 7. Every other opcode selects bypass. Opcodes are shifted in least significant bit first.
- R5: A newly shifted opcode becomes active only on the falling `tck` edge in Update-IR. After the rising edge that enters Update-IR, `regSel` still shows the previous instruction.
- R6: With the identification instruction active, Capture-DR loads `ID_VALUE` (default 32'h327A50CB), which then leaves on `tdo` least significant bit first. The bits shifted in on `tdi` follow it, 32 positions later.
- R7: With bypass active, Capture-DR loads 0, and `tdo` repeats `tdi` one shift later.
- R8: `tdo` and `tdoEn` change only on the falling edge of `tck`. `tdoEn` is 1 exactly in Shift-IR and Shift-DR, and `tdo` is 0 whenever `tdoEn` is 0.
- R9: `captureDr`, `shiftDr` and `updateDr` are 1 exactly while the controller is in Capture-DR, Shift-DR and Update-DR.
- R10: When `regSel` bit k (k = 2 to 7) is set, Shift-DR drives `tdo` from `extTdo[k-2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| extTdo | input | 6 | Serial returns of the outside registers, regSel bits 2 to 7 |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdoEn | output | 1 | Output-enable qualifier for tdo |
| captureDr | output | 1 | Controller is in Capture-DR |
| shiftDr | output | 1 | Controller is in Shift-DR |
| updateDr | output | 1 | Controller is in Update-DR |
| regSel | output | 8 | One-hot data register select |

## Verification
The assertions assume that `tms` and `tdi` are stable at each rising `tck` edge and that `trstN` is released away from a clock edge. Under these assumptions, every state the controller holds since reset follows from the mode-select history. The bench changes `tms`, `tdi` and `extTdo` one time unit after a falling edge and releases reset in mid-period. It reads `tdo`, `tdoEn` and `regSel` after a falling edge, and it reads them directly after a rising edge when it has to show that nothing moved there.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W  = 5;
  localparam int SEL_W = 8;
  localparam int EXT_N = SEL_W - 2;

  localparam int SEL_BYP = 0;
  localparam int SEL_ID  = 1;

  localparam logic [IR_W-1:0] OP_BYPASS = 5'b11111;
  localparam logic [IR_W-1:0] OP_IDENT  = 5'b01000;
  localparam logic [IR_W-1:0] OP_CAPT   = 5'b00001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_t;

  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic shiftIr;
  } dpStrobe_t;
endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             tdi,
  output dpStrobe_t        strb,
  output logic             updateDr,
  output logic             irSo,
  output logic [SEL_W-1:0] regSel
);
  tapState_t state, nextState;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irActive;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nextState = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nextState = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  // Instruction shift stage: rising edge domain
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                 irShift <= OP_CAPT;
    else if (state == ST_CAP_IR) irShift <= OP_CAPT;
    else if (state == ST_SH_IR)  irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // Active instruction: falling edge domain
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)                  irActive <= OP_IDENT;
    else if (state == ST_RESET)  irActive <= OP_IDENT;
    else if (state == ST_UPD_IR) irActive <= irShift;
  end

  always_comb begin
    regSel = '0;
    unique case (irActive)
      OP_IDENT:           regSel[SEL_ID] = 1'b1;
      5'b00000, 5'b00001: regSel[2] = 1'b1;
      5'b00010:           regSel[3] = 1'b1;
      5'b00100:           regSel[4] = 1'b1;
      5'b00101:           regSel[5] = 1'b1;
      5'b00110:           regSel[6] = 1'b1;
      5'b01111:           regSel[7] = 1'b1;
      default:            regSel[SEL_BYP] = 1'b1;
    endcase
  end

  assign strb.captureDr = (state == ST_CAP_DR);
  assign strb.shiftDr   = (state == ST_SH_DR);
  assign strb.shiftIr   = (state == ST_SH_IR);
  assign updateDr       = (state == ST_UPD_DR);
  assign irSo           = irShift[0];

  // Checker support: consecutive high mode-select edges, saturating
  logic [2:0] onesCnt;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)             onesCnt <= '0;
    else if (!tms)          onesCnt <= '0;
    else if (onesCnt != 3'd5) onesCnt <= onesCnt + 3'd1;
  end

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!trstN)
    (onesCnt == 3'd5) |-> (state == ST_RESET));

  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_CAP_IR) |=> (irShift == OP_CAPT));

  a_r5_instr_hold: assert property (@(posedge tck) disable iff (!trstN)
    !(state == ST_UPD_IR || state == ST_RESET) |-> $stable(irActive));

  a_r4_sel_onehot: assert property (@(posedge tck) disable iff (!trstN)
    $countones(regSel) == 1);
endmodule

// File: rtl/tap_dp.sv
module tap_dp
  import tap_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h327A50CB
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  dpStrobe_t        strb,
  input  logic             irSo,
  input  logic [SEL_W-1:0] regSel,
  input  logic [EXT_N-1:0] extTdo,
  output logic             tdo,
  output logic             tdoEn
);
  logic            bypassReg;
  logic [ID_W-1:0] idShift;
  logic [SEL_W-1:0] srcBit;
  logic            drSo;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) bypassReg <= 1'b0;
    else if (regSel[SEL_BYP]) begin
      if (strb.captureDr)    bypassReg <= 1'b0;
      else if (strb.shiftDr) bypassReg <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) idShift <= ID_VALUE;
    else if (regSel[SEL_ID]) begin
      if (strb.captureDr)    idShift <= ID_VALUE;
      else if (strb.shiftDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end
  end

  assign srcBit[SEL_BYP] = bypassReg;
  assign srcBit[SEL_ID]  = idShift[0];
  for (genvar k = 2; k < SEL_W; k++) begin : g_ext
    assign srcBit[k] = extTdo[k-2];
  end

  assign drSo = |(srcBit & regSel);

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdoEn <= strb.shiftDr | strb.shiftIr;
      tdo   <= strb.shiftIr ? irSo : (strb.shiftDr ? drSo : 1'b0);
    end
  end

  a_r8_enable_only_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (strb.shiftDr || strb.shiftIr));

  a_r8_quiet_when_off: assert property (@(posedge tck) disable iff (!trstN)
    !tdoEn |-> !tdo);

  a_r7_bypass_capture: assert property (@(posedge tck) disable iff (!trstN)
    (strb.captureDr && regSel[SEL_BYP]) |=> !bypassReg);
endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h327A50CB
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             tdi,
  input  logic [EXT_N-1:0] extTdo,
  output logic             tdo,
  output logic             tdoEn,
  output logic             captureDr,
  output logic             shiftDr,
  output logic             updateDr,
  output logic [SEL_W-1:0] regSel
);
  dpStrobe_t strb;
  logic      irSo;

  tap_ctrl u_ctrl (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .strb(strb), .updateDr(updateDr), .irSo(irSo), .regSel(regSel)
  );

  tap_dp #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dp (
    .tck(tck), .trstN(trstN), .tdi(tdi), .strb(strb), .irSo(irSo),
    .regSel(regSel), .extTdo(extTdo), .tdo(tdo), .tdoEn(tdoEn)
  );

  assign captureDr = strb.captureDr;
  assign shiftDr   = strb.shiftDr;
endmodule

// File: tb/sim_tap_port.sv
module sim_tap_port;
  localparam int TCK_PERIOD = 10;
  localparam logic [31:0] ID = 32'h327A50CB;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [5:0] extTdo = '0;
  logic tdo, tdoEn, captureDr, shiftDr, updateDr;
  logic [7:0] regSel;
  int checks = 0, errors = 0;

  tap_port u0 (.tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .extTdo(extTdo),
    .tdo(tdo), .tdoEn(tdoEn), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .regSel(regSel));

  always #(TCK_PERIOD/2) tck = ~tck;

  // opcode, expected select
  localparam logic [12:0] VEC [12] = '{
    {5'b11111, 8'h01}, {5'b01000, 8'h02}, {5'b00000, 8'h04}, {5'b00001, 8'h04},
    {5'b00010, 8'h08}, {5'b00100, 8'h10}, {5'b00101, 8'h20}, {5'b00110, 8'h40},
    {5'b01111, 8'h80}, {5'b00011, 8'h01}, {5'b10101, 8'h01}, {5'b01010, 8'h01}};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic toIdle();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  task automatic loadIr(input logic [4:0] op, output logic [4:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) begin
      cap[i] = tdo;
      tick(i == 4, op[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scanDr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0);
    chk("R9 captureDr", {63'd0, captureDr}, 64'd1);
    tick(0, 0);
    chk("R9 shiftDr", {63'd0, shiftDr}, 64'd1);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    chk("R8 enable off in Exit1", {63'd0, tdoEn}, 64'd0);
    tick(1, 0);
    chk("R9 updateDr", {63'd0, updateDr}, 64'd1);
    tick(0, 0);
  endtask

  initial begin
    #(TCK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [4:0] cap;
    logic [63:0] dout;
    #(TCK_PERIOD * 3 + 2);
    chk("R1 reset select", {56'd0, regSel}, 64'h02);
    chk("R1 reset enable", {63'd0, tdoEn}, 64'd0);
    chk("R1 reset strobes", {61'd0, captureDr, shiftDr, updateDr}, 64'd0);
    trstN = 1'b1;
    @(negedge tck); #1;
    tick(0, 0);

    // R6: identifier without any prior instruction scan
    scanDr(64, 64'hFFFF_FFFF_0000_0000, dout);
    chk("R6 identifier out", {32'd0, dout[31:0]}, {32'd0, ID});
    chk("R6 tdi follows", {32'd0, dout[63:32]}, 64'd0);

    // R3 R4: table of opcodes
    foreach (VEC[v]) begin
      loadIr(VEC[v][12:8], cap);
      chk("R3 capture pattern", {59'd0, cap}, 64'h01);
      chk("R4 decode", {56'd0, regSel}, {56'd0, VEC[v][7:0]});
    end

    // R7: bypass one-bit delay
    loadIr(5'b11111, cap);
    scanDr(8, 64'hB5, dout);
    chk("R7 bypass delay", dout, {56'd0, 8'hB5, 1'b0} & 64'hFF);

    // R8: tdo changes on falling edge only
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R8 first bypass bit", {63'd0, tdo}, 64'd0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R8 held at rising edge", {63'd0, tdo}, 64'd0);
    @(negedge tck); #1;
    chk("R8 moves at falling edge", {63'd0, tdo}, 64'd1);
    chk("R8 enabled in shift", {63'd0, tdoEn}, 64'd1);

    // R2: five high edges from Shift-DR reach reset and restore identification
    for (int i = 0; i < 5; i++) tick(1, 0);
    chk("R2 identification after reset", {56'd0, regSel}, 64'h02);
    chk("R2 enable off", {63'd0, tdoEn}, 64'd0);
    tick(0, 0);

    // R5: instruction changes at the falling edge of Update-IR
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(i == 4, cap[i] ^ cap[i] ^ 1'b1);
    tms = 1;
    @(posedge tck); #1;
    chk("R5 old instruction at rising edge", {56'd0, regSel}, 64'h02);
    @(negedge tck); #1;
    chk("R5 new instruction at falling edge", {56'd0, regSel}, 64'h01);
    tick(0, 0);

    // R10: outside register return
    loadIr(5'b00100, cap);
    extTdo = 6'b000100;
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R10 stub bit high", {63'd0, tdo}, 64'd1);
    extTdo = 6'b111011;
    tick(0, 0);
    chk("R10 stub bit low", {63'd0, tdo}, 64'd0);
    tick(1, 0); tick(1, 0); tick(0, 0);

    // R1: asynchronous reset mid-operation
    loadIr(5'b00110, cap);
    #2 trstN = 1'b0; #1;
    chk("R1 async reset select", {56'd0, regSel}, 64'h02);
    #3 trstN = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule